// File: doc/BRIEF.md
# Mode-Selectable Bridge Input Router

This block turns four PWM command inputs into gate requests for four half-bridge output stages, named A to D and held at vector bits 0 to 3. Every stage gets a high-side enable and a low-side enable. It also gets a high-impedance flag that is set when neither switch is requested. A two-bit routing mode selects how the PWM inputs reach the stages:

- Each input can drive its own stage.
- One input can drive a pair of stages in phase, for parallel operation.
- One input can drive a pair of stages in opposite phase, so that a full bridge needs only one command line.

The stages form two pairs: A with B, and C with D. Each pair has its own active-low reset input. A separate current limiter can force any single stage off through a per-stage disable input. The routing mode is captured only while every pair reset is asserted. This keeps the routing stable while the bridges are switching. All outputs are registered. Dead time, current sensing and the power stage itself belong to other blocks.

Top module: `bridge_router`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first clock after it, every stage reports high-impedance with both enables low. The captured routing mode returns to independent (code 0).
- R2: In routing codes 0 and 1 (independent routing), stage i follows `pwm_in[i]`. A high input gives a high-side request only. A low input gives a low-side request only.
- R3: In routing code 2 (parallel), stages A and B (bits 0 and 1) both follow `pwm_in[0]`. Stages C and D (bits 2 and 3) both follow `pwm_in[1]`. `pwm_in[2]` and `pwm_in[3]` have no effect.
- R4: In routing code 3 (complementary), stage A follows `pwm_in[0]` and stage B is its inverse. Stage C follows `pwm_in[2]` and stage D is its inverse. `pwm_in[1]` and `pwm_in[3]` have no effect. For example, a high `pwm_in[0]` requests A high side and B low side.
- R5: In parallel routing, a low on either pair reset makes all four stages high-impedance.
- R6: In the other routing codes, `pair_rst_n[0]` low makes only stages A and B high-impedance. `pair_rst_n[1]` low makes only stages C and D high-impedance.
- R7: A stage's high-impedance flag is set exactly when both of its enables are low. The high-side and low-side enables of a stage are never high together.
- R8: `mode_sel` is captured only on a clock edge where every bit of `pair_rst_n` is low. A change at any other time has no effect on routing.
- R9: `stage_dis[i]` high makes stage i high-impedance, whatever its PWM level. Other stages are unaffected.
- R10: Outputs are registered. Each output reflects the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Routing code: 0/1 independent, 2 parallel, 3 complementary |
| pwm_in | input | 2*NUM_PAIRS | PWM commands, bit 0 = A |
| pair_rst_n | input | NUM_PAIRS | Active-low pair resets, bit 0 = A/B, bit 1 = C/D |
| stage_dis | input | 2*NUM_PAIRS | Per-stage disable from the current limiter |
| hs_en | output | 2*NUM_PAIRS | High-side switch requests |
| ls_en | output | 2*NUM_PAIRS | Low-side switch requests |
| hiz | output | 2*NUM_PAIRS | Stage high-impedance flags |

## Verification
The bench sweeps all sixteen PWM patterns in each routing code. It also drives the inputs that should be ignored to both levels. A router that swapped the pair sources, or that listened to an unused input, would then show a wrong stage level. Single-pair resets are exercised in both parallel and independent routing. This catches a design that tri-states only one pair in parallel mode, and one that tri-states everything in the other modes. The bench also changes `mode_sel` with the bridges running, which exposes a latch that samples it on any clock. It raises disables one stage at a time, which exposes a disable that leaks to a neighbour or loses to the PWM level.

// File: rtl/bridge_router_pkg.sv
`timescale 1ns/1ps
package bridge_router_pkg;
  typedef enum logic [1:0] {
    ROUTE_INDEP_LIMIT = 2'd0,
    ROUTE_INDEP_LATCH = 2'd1,
    ROUTE_PARALLEL    = 2'd2,
    ROUTE_COMPLEMENT  = 2'd3
  } route_mode_e;
endpackage

// File: rtl/bridge_mode_latch.sv
`timescale 1ns/1ps
module bridge_mode_latch
  import bridge_router_pkg::*;
#(
  parameter int NUM_PAIRS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_sel,
  input  logic [NUM_PAIRS-1:0] pair_rst_n,
  output route_mode_e          mode_q
);
  // Routing may only change while every bridge is held off.
  logic all_held;
  assign all_held = ~|pair_rst_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ROUTE_INDEP_LIMIT;
    end else if (all_held) begin
      mode_q <= route_mode_e'(mode_sel);
    end
  end
endmodule

// File: rtl/bridge_input_router.sv
`timescale 1ns/1ps
module bridge_input_router
  import bridge_router_pkg::*;
#(
  parameter int NUM_PAIRS  = 2,
  localparam int NUM_STAGES = 2 * NUM_PAIRS
) (
  input  route_mode_e           mode_q,
  input  logic [NUM_STAGES-1:0] pwm_in,
  input  logic [NUM_PAIRS-1:0]  pair_rst_n,
  output logic [NUM_STAGES-1:0] level,
  output logic [NUM_STAGES-1:0] live
);
  logic all_released;
  assign all_released = &pair_rst_n;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic lvl_even, lvl_odd, pair_live;

    always_comb begin
      case (mode_q)
        ROUTE_PARALLEL: begin
          lvl_even  = pwm_in[p];
          lvl_odd   = pwm_in[p];
          pair_live = all_released;
        end
        ROUTE_COMPLEMENT: begin
          lvl_even  = pwm_in[2*p];
          lvl_odd   = ~pwm_in[2*p];
          pair_live = pair_rst_n[p];
        end
        default: begin
          lvl_even  = pwm_in[2*p];
          lvl_odd   = pwm_in[2*p+1];
          pair_live = pair_rst_n[p];
        end
      endcase
    end

    assign level[2*p]   = lvl_even;
    assign level[2*p+1] = lvl_odd;
    assign live[2*p]    = pair_live;
    assign live[2*p+1]  = pair_live;
  end
endmodule

// File: rtl/bridge_stage_driver.sv
`timescale 1ns/1ps
module bridge_stage_driver (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic live,
  input  logic dis,
  output logic hs_en,
  output logic ls_en,
  output logic hiz
);
  logic conduct;
  assign conduct = live & ~dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
      hiz   <= 1'b1;
    end else begin
      hs_en <= conduct & level;
      ls_en <= conduct & ~level;
      hiz   <= ~conduct;
    end
  end
endmodule

// File: rtl/bridge_router.sv
`timescale 1ns/1ps
module bridge_router
  import bridge_router_pkg::*;
#(
  parameter int NUM_PAIRS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode_sel,
  input  logic [2*NUM_PAIRS-1:0] pwm_in,
  input  logic [NUM_PAIRS-1:0]   pair_rst_n,
  input  logic [2*NUM_PAIRS-1:0] stage_dis,
  output logic [2*NUM_PAIRS-1:0] hs_en,
  output logic [2*NUM_PAIRS-1:0] ls_en,
  output logic [2*NUM_PAIRS-1:0] hiz
);
  localparam int NUM_STAGES = 2 * NUM_PAIRS;

  route_mode_e           mode_q;
  logic [NUM_STAGES-1:0] level;
  logic [NUM_STAGES-1:0] live;

  bridge_mode_latch #(.NUM_PAIRS(NUM_PAIRS)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .pair_rst_n (pair_rst_n),
    .mode_q     (mode_q)
  );

  bridge_input_router #(.NUM_PAIRS(NUM_PAIRS)) u_route (
    .mode_q     (mode_q),
    .pwm_in     (pwm_in),
    .pair_rst_n (pair_rst_n),
    .level      (level),
    .live       (live)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    bridge_stage_driver u_drv (
      .clk   (clk),
      .rst   (rst),
      .level (level[s]),
      .live  (live[s]),
      .dis   (stage_dis[s]),
      .hs_en (hs_en[s]),
      .ls_en (ls_en[s]),
      .hiz   (hiz[s])
    );
  end
endmodule

// File: rtl/bridge_router_chk.sv
`timescale 1ns/1ps
module bridge_router_chk
  import bridge_router_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  localparam int NUM_STAGES = 2 * NUM_PAIRS
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PAIRS-1:0]  pair_rst_n,
  input logic [NUM_STAGES-1:0] stage_dis,
  input logic [NUM_STAGES-1:0] hs_en,
  input logic [NUM_STAGES-1:0] ls_en,
  input logic [NUM_STAGES-1:0] hiz,
  input route_mode_e           mode_q
);
  logic [NUM_PAIRS-1:0] hs_ev, hs_od, ls_ev, ls_od, pair_hiz;
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_split
    assign hs_ev[p]    = hs_en[2*p];
    assign hs_od[p]    = hs_en[2*p+1];
    assign ls_ev[p]    = ls_en[2*p];
    assign ls_od[p]    = ls_en[2*p+1];
    assign pair_hiz[p] = hiz[2*p] & hiz[2*p+1];
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (hs_en & ls_en) == '0); // R7

  AST_HIZ_MATCHES_ENABLES: assert property (@(posedge clk) disable iff (rst)
    hiz == ~(hs_en | ls_en)); // R7

  AST_PAIR_RESET_HIZ: assert property (@(posedge clk) disable iff (rst)
    (pair_rst_n != '1) |=> ((pair_hiz | $past(pair_rst_n)) == '1)); // R6

  AST_PARALLEL_RESET_ALL: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ROUTE_PARALLEL && pair_rst_n != '1) |=> (&hiz)); // R5

  AST_PARALLEL_PAIRS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ROUTE_PARALLEL && stage_dis == '0) |=> (hs_ev == hs_od && ls_ev == ls_od)); // R3

  AST_COMPLEMENT_PAIRS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ROUTE_COMPLEMENT && stage_dis == '0 && pair_rst_n == '1)
      |=> (hs_ev == ls_od && ls_ev == hs_od)); // R4

  AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (stage_dis != '0) |=> ((hiz & $past(stage_dis)) == $past(stage_dis))); // R9

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pair_rst_n != '0) |=> $stable(mode_q)); // R8
endmodule

bind bridge_router bridge_router_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pair_rst_n (pair_rst_n),
  .stage_dis  (stage_dis),
  .hs_en      (hs_en),
  .ls_en      (ls_en),
  .hiz        (hiz),
  .mode_q     (mode_q)
);

// File: tb/bridge_router_tb.sv
`timescale 1ns/1ps
module bridge_router_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic [3:0] pwm_in;
  logic [1:0] pair_rst_n;
  logic [3:0] stage_dis;
  logic [3:0] hs_en, ls_en, hiz;

  int checks   = 0;
  int failures = 0;
  logic [1:0] model_mode = 2'd0;

  typedef struct {
    logic [3:0] hs;
    logic [3:0] ls;
    logic [3:0] hz;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  bridge_router u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pwm_in(pwm_in),
    .pair_rst_n(pair_rst_n), .stage_dis(stage_dis),
    .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz)
  );

  // Driver: applies one cycle of stimulus and queues what the ports must show after the edge.
  task automatic step(input logic r, input logic [1:0] m, input logic [3:0] p,
                      input logic [1:0] prn, input logic [3:0] dis, input string tag);
    exp_t e;
    rst = r; mode_sel = m; pwm_in = p; pair_rst_n = prn; stage_dis = dis;
    e.tag = tag;
    for (int s = 0; s < 4; s++) begin
      logic lvl, ok, on;
      int pr;
      pr = s / 2;
      if (model_mode == 2'd2) begin
        lvl = p[pr];
        ok  = prn[0] & prn[1];
      end else if (model_mode == 2'd3) begin
        lvl = (s % 2 == 1) ? ~p[2*pr] : p[2*pr];
        ok  = prn[pr];
      end else begin
        lvl = p[s];
        ok  = prn[pr];
      end
      on = ok & ~dis[s] & ~r;
      e.hs[s] = on & lvl;
      e.ls[s] = on & ~lvl;
      e.hz[s] = ~on;
    end
    sb.push_back(e);
    if (r) model_mode = 2'd0;
    else if (prn == 2'b00) model_mode = m;
    @(negedge clk);
  endtask

  // Monitor: compares registered outputs shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (hs_en !== e.hs || ls_en !== e.ls || hiz !== e.hz) begin
        failures++;
        $display("FAIL %s: hs=%b ls=%b hiz=%b expected hs=%b ls=%b hiz=%b",
                 e.tag, hs_en, ls_en, hiz, e.hs, e.ls, e.hz);
      end
      checks++;
      if ((hs_en & ls_en) != 4'b0 || hiz !== ~(hs_en | ls_en)) begin
        failures++;
        $display("FAIL R7: hs=%b ls=%b hiz=%b expected disjoint enables and hiz=%b",
                 hs_en, ls_en, hiz, ~(hs_en | ls_en));
      end
    end
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_sel = 2'd2; pwm_in = 4'h0; pair_rst_n = 2'b00; stage_dis = 4'h0;
    @(negedge clk);
    // R1: reset holds all stages off, then routing starts independent
    step(1'b1, 2'd2, 4'hF, 2'b11, 4'h0, "R1");
    step(1'b1, 2'd3, 4'h5, 2'b11, 4'h0, "R1");
    step(1'b0, 2'd2, 4'h5, 2'b11, 4'h0, "R1");
    // R2: independent routing, code 0
    for (int v = 0; v < 16; v++) step(1'b0, 2'd0, 4'(v), 2'b11, 4'h0, "R2");
    // R8: load code 1 with both pairs held
    step(1'b0, 2'd1, 4'hA, 2'b00, 4'h0, "R8");
    for (int v = 15; v >= 0; v--) step(1'b0, 2'd1, 4'(v), 2'b11, 4'h0, "R2");
    // R9: single-stage disables
    for (int s = 0; s < 4; s++) step(1'b0, 2'd1, 4'hF, 2'b11, 4'(1 << s), "R9");
    step(1'b0, 2'd1, 4'h0, 2'b11, 4'h9, "R9");
    // R6: pair resets in independent routing
    step(1'b0, 2'd1, 4'hF, 2'b10, 4'h0, "R6");
    step(1'b0, 2'd1, 4'h0, 2'b01, 4'h0, "R6");
    // R10: alternating pattern, one-cycle latency
    for (int k = 0; k < 6; k++) step(1'b0, 2'd1, (k % 2 == 1) ? 4'h5 : 4'hA, 2'b11, 4'h0, "R10");
    // R3: load parallel routing and sweep
    step(1'b0, 2'd2, 4'h0, 2'b00, 4'h0, "R8");
    for (int v = 0; v < 16; v++) step(1'b0, 2'd2, 4'(v), 2'b11, 4'h0, "R3");
    // R5: either pair reset shuts down everything in parallel routing
    step(1'b0, 2'd2, 4'h3, 2'b10, 4'h0, "R5");
    step(1'b0, 2'd2, 4'h3, 2'b01, 4'h0, "R5");
    step(1'b0, 2'd2, 4'h1, 2'b11, 4'h0, "R3");
    // R8: mode change while running has no effect
    step(1'b0, 2'd3, 4'h4, 2'b11, 4'h0, "R8");
    step(1'b0, 2'd0, 4'hD, 2'b11, 4'h0, "R8");
    step(1'b0, 2'd3, 4'hE, 2'b01, 4'h0, "R8");
    step(1'b0, 2'd0, 4'h2, 2'b11, 4'h0, "R8");
    // R9: disable in parallel routing
    step(1'b0, 2'd2, 4'h3, 2'b11, 4'h2, "R9");
    // R4: load complementary routing and sweep
    step(1'b0, 2'd3, 4'h0, 2'b00, 4'h0, "R8");
    for (int v = 0; v < 16; v++) step(1'b0, 2'd3, 4'(v), 2'b11, 4'h0, "R4");
    step(1'b0, 2'd3, 4'h1, 2'b11, 4'h0, "R4");
    // R6: pair resets in complementary routing
    step(1'b0, 2'd3, 4'h5, 2'b10, 4'h0, "R6");
    step(1'b0, 2'd3, 4'h5, 2'b01, 4'h0, "R6");
    // R9: disable in complementary routing
    step(1'b0, 2'd3, 4'h5, 2'b11, 4'h8, "R9");
    // R1: reset mid-run returns to independent routing
    step(1'b1, 2'd3, 4'h6, 2'b11, 4'h0, "R1");
    step(1'b0, 2'd3, 4'h6, 2'b11, 4'h0, "R1");
    step(1'b0, 2'd3, 4'h9, 2'b11, 4'h0, "R1");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule